// File: doc/BRIEF.md
# Quad-Port Block RAM with Write Arbitration

A single storage array of 512 words, each 18 bits wide, shared by two write ports and two read ports. All four ports can work in the same cycle. Each write port carries two lane enables. Lane 0 is word bits 8:0 and lane 1 is word bits 17:9. A lane enable of 1 stores that lane and leaves the other lane of the word as it was.

When both write ports reach the same word in one cycle with a lane in common, the outcome is set at elaboration. With arbitration on, write port 0 owns each shared lane. With arbitration off, write port 1 lands last and a collision flag pulses. Each read port has two parameters. One selects an address register and the other selects an output register. Clearing both gives a fully combinational read.

Top module: `qpram_top`

## Requirements
- R1: The array holds 512 words of 18 bits. A read returns the last value stored at that address.
- R2: While rst_ni is low, and after it rises until the next read-clock edge, a read port with its output register selected drives 0. wcoll_o is 0 during that time.
- R3: Writes happen on the rising edge of wclk_i. Bit l of a port's lane enable stores lane l only: l=0 stores bits 8:0 and l=1 stores bits 17:9. The other lane keeps its old value.
- R4: Both write ports can store to different addresses on the same edge. The data of write port 1 always lands in every lane it writes that has not been suppressed.
- R5: With ARB_EN=1, write port 0's data is stored in each lane that both ports enable at the same address. Port 1's lanes outside that overlap are still stored.
- R6: With ARB_EN=0, port 1's data is stored in the overlapping lanes. wcoll_o is 1 in the cycle after each edge with an overlap, and 0 after an edge without one. With ARB_EN=1, wcoll_o stays 0.
- R7: With both read registers bypassed, the read data follows the read address combinationally. It shows writes made at earlier edges.
- R8: With only the address register selected, the address is captured on the rclk_i edge. The data then shows the array after that same edge's writes.
- R9: With only the output register selected, the edge captures the array content from before that edge's writes (read-before-write).
- R10: With both registers selected, the data appears two edges after the address. It is sampled before the writes of the second edge.
- R11: The two read ports return data for different addresses independently in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the port registers |
| w0_addr_i | input | 9 | Write port 0 address |
| w0_data_i | input | 18 | Write port 0 data |
| w0_lane_en_i | input | 2 | Write port 0 lane enables |
| w1_addr_i | input | 9 | Write port 1 address |
| w1_data_i | input | 18 | Write port 1 data |
| w1_lane_en_i | input | 2 | Write port 1 lane enables |
| r0_addr_i | input | 9 | Read port 0 address |
| r0_data_o | output | 18 | Read port 0 data |
| r1_addr_i | input | 9 | Read port 1 address |
| r1_data_o | output | 18 | Read port 1 data |
| wcoll_o | output | 1 | Same-word lane collision seen on the previous write edge |

## Verification
A bad lane mask or a wrong arbitration winner leaves a corrupt word in the array. The combinational read port shows it at once. The registered read ports show it one or two edges later. A read-path register that is present when it should be bypassed, or bypassed when it should be present, moves the data by one edge. A reference model of each register configuration catches that shift on the first read whose address changes. A wrong collision flag appears on wcoll_o in the cycle right after the offending edge.

// File: rtl/qpram_pkg.sv
package qpram_pkg;
  localparam int unsigned QP_DEPTH  = 512;
  localparam int unsigned QP_LANE_W = 9;
  localparam int unsigned QP_LANES  = 2;
endpackage

// File: rtl/qpram_wr_arb.sv
module qpram_wr_arb #(
  parameter int unsigned AW     = 9,
  parameter int unsigned LANES  = 2,
  parameter bit          ARB_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    a0_i,
  input  logic [LANES-1:0] en0_i,
  input  logic [AW-1:0]    a1_i,
  input  logic [LANES-1:0] en1_i,
  output logic [LANES-1:0] en0_eff_o,
  output logic [LANES-1:0] en1_eff_o,
  output logic             coll_o
);
  logic [LANES-1:0] overlap;
  logic             coll_q;

  assign overlap   = (a0_i == a1_i) ? (en0_i & en1_i) : '0;
  assign en0_eff_o = en0_i;
  // port 0 keeps shared lanes when arbitrating; otherwise port 1 lands last
  assign en1_eff_o = ARB_EN ? (en1_i & ~overlap) : en1_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) coll_q <= 1'b0;
    else         coll_q <= !ARB_EN && (|overlap);
  end
  assign coll_o = coll_q;

  // R6
  coll_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ARB_EN == 1'b0) && (a0_i == a1_i) && (|(en0_i & en1_i))) |=> coll_o);
  // R6
  coll_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((a0_i == a1_i) && (|(en0_i & en1_i))) |=> !coll_o);
endmodule

// File: rtl/qpram_array.sv
module qpram_array #(
  parameter int unsigned DEPTH  = 512,
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 2,
  parameter bit          ARB_EN = 1'b1,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic                             wclk_i,
  input  logic                             rst_ni,
  input  logic [AW-1:0]                    wa0_i,
  input  logic [LANES-1:0][LANE_W-1:0]     wd0_i,
  input  logic [LANES-1:0]                 we0_i,
  input  logic [AW-1:0]                    wa1_i,
  input  logic [LANES-1:0][LANE_W-1:0]     wd1_i,
  input  logic [LANES-1:0]                 we1_i,
  input  logic [AW-1:0]                    ra0_i,
  input  logic [AW-1:0]                    ra1_i,
  output logic [LANES-1:0][LANE_W-1:0]     rd0_o,
  output logic [LANES-1:0][LANE_W-1:0]     rd1_o
);
  logic [LANES-1:0][LANE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    for (int l = 0; l < LANES; l++) begin
      if (we0_i[l]) mem_q[wa0_i][l] <= wd0_i[l];
      if (we1_i[l]) mem_q[wa1_i][l] <= wd1_i[l];
    end
  end

  assign rd0_o = mem_q[ra0_i];
  assign rd1_o = mem_q[ra1_i];

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    // R4
    wr1_land_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
      we1_i[g] |=> (mem_q[$past(wa1_i)][g] == $past(wd1_i[g])));
    if (ARB_EN) begin : g_arb
      // R5
      arb_win_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
        we0_i[g] |=> (mem_q[$past(wa0_i)][g] == $past(wd0_i[g])));
    end
  end
endmodule

// File: rtl/qpram_rd_path.sv
module qpram_rd_path #(
  parameter int unsigned AW       = 9,
  parameter int unsigned DW       = 18,
  parameter bit          ADDR_REG = 1'b1,
  parameter bit          OUT_REG  = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] raddr_i,
  output logic [AW-1:0] arr_addr_o,
  input  logic [DW-1:0] arr_data_i,
  output logic [DW-1:0] rdata_o
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= raddr_i;
  end

  assign arr_addr_o = ADDR_REG ? addr_q : raddr_i;

  // sampled before same-edge writes land: read-before-write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= '0;
    else         data_q <= arr_data_i;
  end

  assign rdata_o = OUT_REG ? data_q : arr_data_i;
endmodule

// File: rtl/qpram_top.sv
module qpram_top
  import qpram_pkg::*;
#(
  parameter int unsigned DEPTH       = QP_DEPTH,
  parameter int unsigned LANE_W      = QP_LANE_W,
  parameter int unsigned LANES       = QP_LANES,
  parameter bit          ARB_EN      = 1'b1,
  parameter bit          R0_ADDR_REG = 1'b1,
  parameter bit          R0_OUT_REG  = 1'b1,
  parameter bit          R1_ADDR_REG = 1'b0,
  parameter bit          R1_OUT_REG  = 1'b0,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned DW = LANE_W * LANES
) (
  input  logic             wclk_i,
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    w0_addr_i,
  input  logic [DW-1:0]    w0_data_i,
  input  logic [LANES-1:0] w0_lane_en_i,
  input  logic [AW-1:0]    w1_addr_i,
  input  logic [DW-1:0]    w1_data_i,
  input  logic [LANES-1:0] w1_lane_en_i,
  input  logic [AW-1:0]    r0_addr_i,
  output logic [DW-1:0]    r0_data_o,
  input  logic [AW-1:0]    r1_addr_i,
  output logic [DW-1:0]    r1_data_o,
  output logic             wcoll_o
);
  logic [LANES-1:0]             we0_eff, we1_eff;
  logic [LANES-1:0][LANE_W-1:0] wd0, wd1, ard0, ard1;
  logic [AW-1:0]                ara0, ara1;
  logic [DW-1:0]                ard0_flat, ard1_flat;

  assign wd0       = w0_data_i;
  assign wd1       = w1_data_i;
  assign ard0_flat = ard0;
  assign ard1_flat = ard1;

  qpram_wr_arb #(.AW(AW), .LANES(LANES), .ARB_EN(ARB_EN)) u_arb (
    .clk_i    (wclk_i),
    .rst_ni   (rst_ni),
    .a0_i     (w0_addr_i),
    .en0_i    (w0_lane_en_i),
    .a1_i     (w1_addr_i),
    .en1_i    (w1_lane_en_i),
    .en0_eff_o(we0_eff),
    .en1_eff_o(we1_eff),
    .coll_o   (wcoll_o)
  );

  qpram_array #(.DEPTH(DEPTH), .LANE_W(LANE_W), .LANES(LANES), .ARB_EN(ARB_EN)) u_array (
    .wclk_i(wclk_i),
    .rst_ni(rst_ni),
    .wa0_i (w0_addr_i),
    .wd0_i (wd0),
    .we0_i (we0_eff),
    .wa1_i (w1_addr_i),
    .wd1_i (wd1),
    .we1_i (we1_eff),
    .ra0_i (ara0),
    .ra1_i (ara1),
    .rd0_o (ard0),
    .rd1_o (ard1)
  );

  qpram_rd_path #(.AW(AW), .DW(DW), .ADDR_REG(R0_ADDR_REG), .OUT_REG(R0_OUT_REG)) u_rd0 (
    .clk_i     (rclk_i),
    .rst_ni    (rst_ni),
    .raddr_i   (r0_addr_i),
    .arr_addr_o(ara0),
    .arr_data_i(ard0_flat),
    .rdata_o   (r0_data_o)
  );

  qpram_rd_path #(.AW(AW), .DW(DW), .ADDR_REG(R1_ADDR_REG), .OUT_REG(R1_OUT_REG)) u_rd1 (
    .clk_i     (rclk_i),
    .rst_ni    (rst_ni),
    .raddr_i   (r1_addr_i),
    .arr_addr_o(ara1),
    .arr_data_i(ard1_flat),
    .rdata_o   (r1_data_o)
  );
endmodule

// File: tb/tb_qpram_top.sv
module tb_qpram_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [8:0]  w0a, w1a, ra0, ra1;
  logic [17:0] w0d, w1d;
  logic [1:0]  w0e, w1e;
  logic [17:0] r0_a, r1_a, r0_b, r1_b;
  logic        coll_a, coll_b;

  qpram_top dut (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_n),
    .w0_addr_i(w0a), .w0_data_i(w0d), .w0_lane_en_i(w0e),
    .w1_addr_i(w1a), .w1_data_i(w1d), .w1_lane_en_i(w1e),
    .r0_addr_i(ra0), .r0_data_o(r0_a),
    .r1_addr_i(ra1), .r1_data_o(r1_a),
    .wcoll_o(coll_a)
  );

  qpram_top #(.ARB_EN(1'b0), .R0_ADDR_REG(1'b1), .R0_OUT_REG(1'b0),
              .R1_ADDR_REG(1'b0), .R1_OUT_REG(1'b1)) dut_x (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_n),
    .w0_addr_i(w0a), .w0_data_i(w0d), .w0_lane_en_i(w0e),
    .w1_addr_i(w1a), .w1_data_i(w1d), .w1_lane_en_i(w1e),
    .r0_addr_i(ra0), .r0_data_o(r0_b),
    .r1_addr_i(ra1), .r1_data_o(r1_b),
    .wcoll_o(coll_b)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  bit chk_on = 1'b0;

  // model: array 0 = arbitrating dut, array 1 = dut_x
  logic [17:0] ref_m [2][512];
  logic [8:0]  aq [4];
  logic [17:0] dq [4];
  logic        exp_coll_b;
  bit cfg_a [4] = '{1'b1, 1'b0, 1'b1, 1'b0};
  bit cfg_o [4] = '{1'b1, 1'b0, 1'b0, 1'b1};

  function automatic logic [17:0] fill_val(input logic [8:0] a);
    return {a, ~a};
  endfunction

  function automatic logic [8:0] ra_of(input int p);
    return (p % 2 == 0) ? ra0 : ra1;
  endfunction

  function automatic logic [17:0] exp_of(input int p);
    if (cfg_o[p]) return dq[p];
    if (cfg_a[p]) return ref_m[p / 2][aq[p]];
    return ref_m[p / 2][ra_of(p)];
  endfunction

  function automatic logic [17:0] act_of(input int p);
    case (p)
      0: return r0_a;
      1: return r1_a;
      2: return r0_b;
      default: return r1_b;
    endcase
  endfunction

  function automatic string tag_of(input int p);
    if (cfg_o[p] && cfg_a[p]) return "R10";
    if (cfg_o[p]) return "R9";
    if (cfg_a[p]) return "R8";
    return "R7";
  endfunction

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_all();
    for (int p = 0; p < 4; p++) chk(tag_of(p), act_of(p), exp_of(p));
    chk("R6", {17'd0, coll_a}, 18'd0);
    chk("R6", {17'd0, coll_b}, {17'd0, exp_coll_b});
  endtask

  task automatic model_update();
    for (int p = 0; p < 4; p++) begin
      dq[p] = ref_m[p / 2][cfg_a[p] ? aq[p] : ra_of(p)];
      aq[p] = ra_of(p);
    end
    for (int m = 0; m < 2; m++) begin
      for (int l = 0; l < 2; l++) begin
        if (w0e[l]) ref_m[m][w0a][l*9 +: 9] = w0d[l*9 +: 9];
        if (w1e[l] && !(m == 0 && w0a == w1a && w0e[l]))
          ref_m[m][w1a][l*9 +: 9] = w1d[l*9 +: 9];
      end
    end
    exp_coll_b = (w0a == w1a) && (|(w0e & w1e));
  endtask

  task automatic cyc(input logic [8:0] a0, input logic [17:0] d0, input logic [1:0] e0,
                     input logic [8:0] a1, input logic [17:0] d1, input logic [1:0] e1,
                     input logic [8:0] r0, input logic [8:0] r1);
    @(negedge clk);
    w0a = a0; w0d = d0; w0e = e0;
    w1a = a1; w1d = d1; w1e = e1;
    ra0 = r0; ra1 = r1;
    #1;
    if (chk_on) check_all();
    @(posedge clk);
    #1;
    model_update();
  endtask

  task automatic idle_read(input logic [8:0] r0, input logic [8:0] r1);
    cyc(9'd0, 18'd0, 2'b00, 9'd0, 18'd0, 2'b00, r0, r1);
  endtask

  function automatic logic [8:0] rnd_addr();
    return ($urandom % 2 == 0) ? 9'($urandom % 8) : 9'($urandom % 512);
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_err++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 512; a++) ref_m[m][a] = '0;
    for (int p = 0; p < 4; p++) begin aq[p] = '0; dq[p] = '0; end
    exp_coll_b = 1'b0;
    w0a = '0; w0d = '0; w0e = '0; w1a = '0; w1d = '0; w1e = '0; ra0 = '0; ra1 = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R2: registered outputs and flags cleared
    chk("R2", r0_a, 18'd0);
    chk("R2", r1_b, 18'd0);
    chk("R2", {17'd0, coll_a}, 18'd0);
    chk("R2", {17'd0, coll_b}, 18'd0);

    // fill: both ports store in parallel (R4)
    for (int i = 0; i < 256; i++)
      cyc(9'(i), fill_val(9'(i)), 2'b11, 9'(i + 256), fill_val(9'(i + 256)), 2'b11, 9'd0, 9'd0);
    idle_read(9'd0, 9'd0);
    idle_read(9'd0, 9'd0);
    chk_on = 1'b1;

    // R1 / R11 / R4: independent reads of both halves
    idle_read(9'd300, 9'd12);
    idle_read(9'd300, 9'd12);
    chk("R1", r0_a, fill_val(9'd300));
    chk("R11", r1_a, fill_val(9'd12));
    chk("R4", r0_b, fill_val(9'd300));
    chk("R11", r1_b, fill_val(9'd12));

    // R3: lane-only write
    cyc(9'd9, 18'h12345, 2'b11, 9'd0, 18'd0, 2'b00, 9'd0, 9'd0);
    cyc(9'd9, 18'h3FFFF, 2'b10, 9'd0, 18'd0, 2'b00, 9'd0, 9'd0);
    idle_read(9'd9, 9'd9);
    idle_read(9'd9, 9'd9);
    chk("R3", r1_a, 18'h3FF45);
    chk("R3", r0_b, 18'h3FF45);

    // R5/R6: full-lane collision
    cyc(9'd5, 18'h00111, 2'b11, 9'd5, 18'h3FEEE, 2'b11, 9'd5, 9'd5);
    chk("R6", {17'd0, coll_b}, 18'd1);
    chk("R6", {17'd0, coll_a}, 18'd0);
    idle_read(9'd5, 9'd5);
    chk("R6", {17'd0, coll_b}, 18'd0);
    idle_read(9'd5, 9'd5);
    chk("R5", r1_a, 18'h00111);
    chk("R6", r0_b, 18'h3FEEE);

    // R5: partial overlap, port 1 keeps its non-shared lane
    cyc(9'd6, 18'h00011, 2'b01, 9'd6, 18'h3FEEE, 2'b11, 9'd6, 9'd6);
    idle_read(9'd6, 9'd6);
    idle_read(9'd6, 9'd6);
    chk("R5", r1_a, 18'h3FE11);
    chk("R6", r0_b, 18'h3FEEE);

    // R9/R8/R7: read and write the same word on one edge
    idle_read(9'd7, 9'd7);
    cyc(9'd7, 18'h0ABCD, 2'b11, 9'd0, 18'd0, 2'b00, 9'd7, 9'd7);
    chk("R9", r1_b, fill_val(9'd7));
    chk("R8", r0_b, 18'h0ABCD);
    chk("R7", r1_a, 18'h0ABCD);
    idle_read(9'd7, 9'd7);
    chk("R10", r0_a, 18'h0ABCD);

    // random traffic against the model, every port every cycle
    for (int i = 0; i < 3000; i++)
      cyc(rnd_addr(), 18'($urandom), 2'($urandom), rnd_addr(), 18'($urandom), 2'($urandom),
          rnd_addr(), rnd_addr());

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule